// File: doc/BRIEF.md
# UART receive holding buffer

This block sits between a UART receiver core and the register bus of a 16550-style serial port. The receiver core hands over each assembled character with a one-cycle valid strobe. The block keeps the characters either in one holding register or in a 16-entry receive FIFO, depending on a FIFO-enable control bit. It raises a data-ready flag while an unread character is held, and a sticky overrun flag when a character cannot be stored as intended.

Register offset zero is shared three ways, under the divisor-latch access bit (DLAB). With DLAB clear, a read returns the oldest unread character and removes it, and a write is passed on to the transmit holding register as a one-cycle load pulse. With DLAB set, reads and writes at that offset reach the low byte of the divisor latch, which this block holds. Character selection between the plain and infrared serial inputs happens upstream, so the block sees a single character stream.

Top module: `uart_rx_hold`

## Requirements
- R1: After reset, data_ready and overrun are 0, the divisor low byte is 0, and a DLAB-clear read at offset zero returns 0.
- R2: A read at offset zero puts the 8-bit character or divisor byte on bus_rdata[7:0] and always drives bus_rdata[31:8] to zero.
- R3: A write at offset zero with DLAB clear pulses thr_load in that same cycle with thr_data equal to bus_wdata[7:0], and leaves the divisor low byte unchanged.
- R4: A write at offset zero with DLAB set loads bus_wdata[7:0] into the divisor low byte from the next cycle on, without pulsing thr_load. A read with DLAB set returns that byte and removes no received character.
- R5: data_ready is 1 exactly while at least one received character is unread.
- R6: With fifo_en at 0, a character that arrives while an earlier one is unread replaces it, overrun is set, and the next read returns the newer character.
- R7: With fifo_en at 1, up to 16 characters are held, and reads return them oldest first, each read removing one.
- R8: With fifo_en at 1 and all 16 entries in use, an arriving character without a read in the same cycle is discarded, overrun is set, and the 16 stored characters are read back unchanged.
- R9: With fifo_en at 1 and all 16 entries in use, a read and an arrival in the same cycle return the oldest entry, store the new character as the youngest, and leave overrun clear.
- R10: overrun stays set until a cycle with lsr_rd high. When a new overrun event coincides with lsr_rd, overrun stays set.
- R11: A change of fifo_en empties the storage, so data_ready is 0 in the next cycle. A character arriving in that same cycle is discarded without setting overrun.
- R12: A DLAB-clear read at offset zero with nothing unread returns 0 and has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| rx_valid | input | 1 | One-cycle strobe: a new character is on rx_char |
| rx_char | input | 8 | Character from the receiver core |
| fifo_en | input | 1 | 1 selects the 16-entry FIFO, 0 the single holding register |
| dlab | input | 1 | Divisor-latch access bit |
| bus_sel | input | 1 | Bus access targets offset zero |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data at offset zero, zero when bus_sel is low |
| lsr_rd | input | 1 | Line status register read strobe, clears overrun |
| data_ready | output | 1 | At least one unread character is held |
| overrun | output | 1 | Sticky overrun flag |
| thr_load | output | 1 | Load pulse for the transmit holding register |
| thr_data | output | 8 | Byte for the transmit holding register |
| div_lo | output | 8 | Low byte of the divisor latch |

## Verification
The hardest case to reach from the ports is a full FIFO meeting a read and an arrival in the same cycle. Right next to it is an arrival in the same cycle as a change of fifo_en. The bench fills the FIFO to exactly sixteen entries, then raises rx_valid and the offset-zero read together in one cycle, and drains the FIFO to check both the order and the youngest entry. In the same way, it switches fifo_en in the cycle that carries a character, and confirms that nothing was kept and that overrun stayed clear. The single-register path is swept over all 256 character values.

// File: rtl/uart_rx_hold_pkg.sv
package uart_rx_hold_pkg;

  typedef enum logic [0:0] {
    MODE_SINGLE = 1'b0,
    MODE_FIFO   = 1'b1
  } rx_mode_e;

  // One cycle of storage activity, decided by the control unit.
  typedef struct packed {
    logic flush;    // empty the storage
    logic push;     // append at the write pointer
    logic pop;      // retire the oldest entry
    logic clobber;  // overwrite the oldest entry in place
  } rx_op_t;

endpackage

// File: rtl/rxh_rst_sync.sv
module rxh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/rxh_ctrl.sv
module rxh_ctrl
  import uart_rx_hold_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             rx_valid,
  input  logic             rd_req,
  input  logic             lsr_rd,
  input  logic [CNT_W-1:0] count,
  output rx_op_t           op,
  output logic             mode_change,
  output logic             overrun
);

  rx_mode_e         mode_q, mode_req;
  logic [CNT_W-1:0] cap;
  logic             full, empty, ovf_evt;
  logic             ovr_q, ovr_d, ovr_en;

  always_comb begin
    mode_req    = fifo_en ? MODE_FIFO : MODE_SINGLE;
    mode_change = (mode_req != mode_q);
    cap         = (mode_q == MODE_FIFO) ? CNT_W'(DEPTH) : CNT_W'(1);
    full        = (count == cap);
    empty       = (count == '0);

    op.flush    = mode_change;
    op.pop      = rd_req && !empty && !mode_change;
    ovf_evt     = rx_valid && !mode_change && full && !op.pop;
    op.clobber  = ovf_evt && (mode_q == MODE_SINGLE);
    op.push     = rx_valid && !mode_change && !ovf_evt;

    ovr_en      = ovf_evt || lsr_rd;
    ovr_d       = ovf_evt;  // a fresh event outranks the clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= MODE_SINGLE;
    else if (mode_change) mode_q <= mode_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (ovr_en) ovr_q <= ovr_d;
  end

  assign overrun = ovr_q;

endmodule

// File: rtl/rxh_store.sv
module rxh_store
  import uart_rx_hold_pkg::*;
#(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rx_op_t           op,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d   = rd_q;
    wr_d   = wr_q;
    cnt_d  = cnt_q;
    ptr_en = op.flush || op.push || op.pop;
    if (op.flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (op.push) wr_d = step(wr_q);
      if (op.pop)  rd_d = step(rd_q);
      cnt_d = cnt_q + CNT_W'(op.push) - CNT_W'(op.pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // Data array carries no reset; only entries below the count are read.
  always_ff @(posedge clk) begin
    if (op.push)         mem[wr_q] <= din;
    else if (op.clobber) mem[rd_q] <= din;
  end

  assign head  = (cnt_q != '0) ? mem[rd_q] : '0;
  assign count = cnt_q;

endmodule

// File: rtl/rxh_port.sv
module rxh_port #(
  parameter int BUS_W = 32,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rd,
  input  logic             wr,
  input  logic             dlab,
  input  logic [BUS_W-1:0] wdata,
  input  logic [W-1:0]     head,
  output logic             rd_req,
  output logic [BUS_W-1:0] rdata,
  output logic             thr_load,
  output logic [W-1:0]     thr_data,
  output logic [W-1:0]     dll
);

  logic [W-1:0] dll_q, dll_d, rbyte;
  logic         dll_en;

  always_comb begin
    rd_req   = sel && rd && !dlab;
    thr_load = sel && wr && !dlab;
    thr_data = wdata[W-1:0];
    dll_en   = sel && wr && dlab;
    dll_d    = wdata[W-1:0];
    rbyte    = dlab ? dll_q : head;
    rdata    = sel ? {{(BUS_W - W){1'b0}}, rbyte} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dll_q <= '0;
    else if (dll_en) dll_q <= dll_d;
  end

  assign dll = dll_q;

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_hold_pkg::*;
#(
  parameter  int CHAR_W      = 8,
  parameter  int BUS_W       = 32,
  parameter  int RX_DEPTH    = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              fifo_en,
  input  logic              dlab,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              lsr_rd,
  output logic              data_ready,
  output logic              overrun,
  output logic              thr_load,
  output logic [CHAR_W-1:0] thr_data,
  output logic [CHAR_W-1:0] div_lo
);

  logic              rst_sync_n;
  rx_op_t            op;
  logic              mode_change;
  logic              rd_req;
  logic [CNT_W-1:0]  count;
  logic [CHAR_W-1:0] head;

  rxh_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxh_ctrl #(.DEPTH(RX_DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fifo_en     (fifo_en),
    .rx_valid    (rx_valid),
    .rd_req      (rd_req),
    .lsr_rd      (lsr_rd),
    .count       (count),
    .op          (op),
    .mode_change (mode_change),
    .overrun     (overrun)
  );

  rxh_store #(.W(CHAR_W), .DEPTH(RX_DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op    (op),
    .din   (rx_char),
    .head  (head),
    .count (count)
  );

  rxh_port #(.BUS_W(BUS_W), .W(CHAR_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel      (bus_sel),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .dlab     (dlab),
    .wdata    (bus_wdata),
    .head     (head),
    .rd_req   (rd_req),
    .rdata    (bus_rdata),
    .thr_load (thr_load),
    .thr_data (thr_data),
    .dll      (div_lo)
  );

  assign data_ready = (count != '0);

endmodule

// File: rtl/uart_rx_hold_chk.sv
module uart_rx_hold_chk #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int CHAR_W = 8,
  parameter int BUS_W  = 32
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             rx_valid,
  input logic             dlab,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             lsr_rd,
  input logic             data_ready,
  input logic             overrun,
  input logic             thr_load,
  input logic [CHAR_W-1:0] div_lo,
  input logic [CNT_W-1:0] count,
  input logic             mode_change,
  input logic             pop
);

  // R10: flag holds until the status read
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    overrun && !lsr_rd |=> overrun);

  // R6 / R8: overrun only ever rises after an arrival
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(overrun) |-> $past(rx_valid));

  // R8: a full FIFO keeps its count and flags the dropped character
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count == CNT_W'(DEPTH)) && rx_valid && !pop && !mode_change
      |=> overrun && (count == CNT_W'(DEPTH)));

  // R11: a mode change leaves nothing unread
  assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_change |=> !data_ready);

  // R4: divisor byte follows a DLAB write
  assert_div_load_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_sel && bus_wr && dlab |=> div_lo == $past(bus_wdata[CHAR_W-1:0]));

  // R3 / R4: no transmit load while the divisor latch is addressed
  assert_no_thr_dlab_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dlab |-> !thr_load);

endmodule

bind uart_rx_hold uart_rx_hold_chk #(
  .DEPTH  (RX_DEPTH),
  .CNT_W  (CNT_W),
  .CHAR_W (CHAR_W),
  .BUS_W  (BUS_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .rx_valid    (rx_valid),
  .dlab        (dlab),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .lsr_rd      (lsr_rd),
  .data_ready  (data_ready),
  .overrun     (overrun),
  .thr_load    (thr_load),
  .div_lo      (div_lo),
  .count       (count),
  .mode_change (mode_change),
  .pop         (op.pop)
);

// File: tb/uart_rx_hold_test.sv
module uart_rx_hold_test;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, fifo_en, dlab, bus_sel, bus_rd, bus_wr, lsr_rd;
  logic [7:0]  rx_char;
  logic [31:0] bus_wdata, bus_rdata;
  logic        data_ready, overrun, thr_load;
  logic [7:0]  thr_data, div_lo;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] rd_s;
  logic        thr_s;
  logic [7:0]  thrd_s;

  always #5 clk = ~clk;

  uart_rx_hold uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .fifo_en(fifo_en), .dlab(dlab), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lsr_rd(lsr_rd), .data_ready(data_ready), .overrun(overrun),
    .thr_load(thr_load), .thr_data(thr_data), .div_lo(div_lo)
  );

  function automatic logic [7:0] fv(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 0; rx_char = 0; bus_sel = 0; bus_rd = 0; bus_wr = 0;
    bus_wdata = 0; lsr_rd = 0;
  endtask

  // One cycle: drive at the falling edge, capture combinational outputs,
  // return at the next falling edge with registered outputs updated.
  task automatic drive(input logic v, input logic [7:0] d, input logic rd,
                       input logic wr, input logic dl, input logic [31:0] wd,
                       input logic lsr);
    rx_valid = v; rx_char = d; bus_sel = rd | wr; bus_rd = rd; bus_wr = wr;
    dlab = dl; bus_wdata = wd; lsr_rd = lsr;
    #1;
    rd_s = bus_rdata; thr_s = thr_load; thrd_s = thr_data;
    @(negedge clk);
    idle();
  endtask

  task automatic push(input logic [7:0] d);
    drive(1, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd0();
    drive(0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic lsr();
    drive(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; fifo_en = 0; dlab = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 data_ready", 32'(data_ready), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 div_lo", 32'(div_lo), 0);
    rd0();
    chk("R12 empty read", rd_s, 0);
    chk("R12 still empty", 32'(data_ready), 0);

    // R4: divisor latch under DLAB
    drive(0, 0, 0, 1, 1, 32'h1234_56A5, 0);
    chk("R4 no thr_load", 32'(thr_s), 0);
    chk("R4 div_lo", 32'(div_lo), 32'hA5);
    drive(0, 0, 1, 0, 1, 0, 0);
    chk("R4 dll read", rd_s, 32'h0000_00A5);

    // R3: transmit holding write
    drive(0, 0, 0, 1, 0, 32'hFFFF_FF3C, 0);
    chk("R3 thr_load", 32'(thr_s), 1);
    chk("R3 thr_data", 32'(thrd_s), 32'h3C);
    chk("R3 dll kept", 32'(div_lo), 32'hA5);

    // R2 / R5: single-register sweep over every character value
    for (int v = 0; v < 256; v++) begin
      push(8'(v));
      chk("R5 ready after arrival", 32'(data_ready), 1);
      rd0();
      chk("R2 char on low byte", rd_s, 32'(v));
      chk("R5 ready after read", 32'(data_ready), 0);
    end
    chk("R6 no overrun in sweep", 32'(overrun), 0);

    // R4: DLAB read removes no character
    push(8'h6D);
    drive(0, 0, 1, 0, 1, 0, 0);
    chk("R4 dll read with char", rd_s, 32'hA5);
    chk("R4 char kept", 32'(data_ready), 1);
    rd0();
    chk("R4 char after dll read", rd_s, 32'h6D);

    // R6: overwrite in single-register mode
    push(8'h11);
    push(8'h22);
    chk("R6 overrun", 32'(overrun), 1);
    rd0();
    chk("R6 newest kept", rd_s, 32'h22);
    chk("R6 emptied", 32'(data_ready), 0);

    // R10: sticky until status read, event beats clear
    repeat (3) drive(0, 0, 0, 0, 0, 0, 0);
    chk("R10 sticky", 32'(overrun), 1);
    lsr();
    chk("R10 cleared", 32'(overrun), 0);
    push(8'h33);
    drive(1, 8'h55, 0, 0, 0, 0, 1);
    chk("R10 event with clear", 32'(overrun), 1);
    lsr();
    chk("R10 cleared again", 32'(overrun), 0);

    // R11: mode change flushes, coincident arrival dropped
    chk("R11 ready before", 32'(data_ready), 1);
    fifo_en = 1;
    push(8'h99);
    chk("R11 flushed", 32'(data_ready), 0);
    chk("R11 no overrun", 32'(overrun), 0);
    rd0();
    chk("R12 read after flush", rd_s, 0);

    // R7: FIFO order
    for (int i = 0; i < DEPTH; i++) push(fv(i));
    chk("R7 no overrun at depth", 32'(overrun), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd0();
      chk("R7 order", rd_s, 32'(fv(i)));
    end
    chk("R7 drained", 32'(data_ready), 0);

    // R8: full FIFO drops arrival
    for (int i = 0; i < DEPTH; i++) push(fv(i + 40));
    push(8'hEE);
    chk("R8 overrun", 32'(overrun), 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd0();
      chk("R8 contents kept", rd_s, 32'(fv(i + 40)));
    end
    chk("R8 drained", 32'(data_ready), 0);
    lsr();

    // R9: full FIFO with read and arrival together
    for (int i = 0; i < DEPTH; i++) push(fv(i + 90));
    drive(1, 8'h5A, 1, 0, 0, 0, 0);
    chk("R9 oldest returned", rd_s, 32'(fv(90)));
    chk("R9 no overrun", 32'(overrun), 0);
    for (int i = 1; i < DEPTH; i++) begin
      rd0();
      chk("R9 order", rd_s, 32'(fv(i + 90)));
    end
    rd0();
    chk("R9 newest last", rd_s, 32'h5A);
    chk("R9 drained", 32'(data_ready), 0);

    // R11: leaving FIFO mode with data held
    push(8'h01);
    push(8'h02);
    fifo_en = 0;
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R11 flush on disable", 32'(data_ready), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule